// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that gives a host access to a small bank of 8-bit configuration registers. The host pulls chip select low and clocks a 16-bit command frame in on the data line, most significant bit first. Each rising serial clock edge captures one bit. When chip select returns high, the block decodes the frame. A write command stores its data byte in the addressed register. A read command copies the addressed register into the low byte of the shift register. The next frame shifts that value out on the data out line while it carries in the next command, which may be a no-op.

The serial clock, chip select and data inputs are asynchronous to the system clock. They pass through synchronizers, and every decision is made on edges detected in the system clock domain. The register contents are also presented on a flat parallel bus so that the rest of the chip can use them.

Top module: `serial_reg_port`

## Requirements
- R1: After reset every implemented register holds 0x00, so the mode register's run bit (bit 0 of address 0x04) is clear and the device is in shutdown, and the data out line is low.
- R2: While chip select is low, each rising serial clock edge shifts the data in value into bit 0 of the 16-bit shift register, and the older bits move one place toward bit 15. The first bit sent therefore ends up as bit 15.
- R3: If more than 16 bits are clocked in during one chip-select-low period, only the last 16 bits decide the command.
- R4: A frame with bit 15 low is a write. Bits 14..8 give the address and bits 7..0 give the data. At the rising edge of chip select, the data is stored in the register at that address if the address is in 1..LAST_ADDR. No other register changes.
- R5: A write to address 0x00 (no-op) or to an address above LAST_ADDR changes no register.
- R6: A frame with bit 15 high is a read. At the rising edge of chip select, shift register bits 7..0 are replaced by the addressed register and bits 15..8 keep the command. During the next frame the first 8 bits out are {1, address} and the second 8 bits out are the register contents.
- R7: A read of address 0x00 or of any address above LAST_ADDR returns 0x00.
- R8: Raising chip select while the serial clock is still high after the last bit gives the same result as raising it after the serial clock has returned low.
- R9: Data out shows the shift register's bit 15. It updates only on a falling serial clock edge inside a frame and on the falling edge of chip select, and it holds its value through the high phase of the serial clock.
- R10: After a write frame, the next frame shifts out the write frame exactly as it was received.
- R11: Serial clock edges while chip select is high do not change the shift register or any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial data in, captured on rising serial clock |
| dout | output | 1 | Serial data out, updated on falling serial clock |
| regBus | output | 8*LAST_ADDR | Register contents, address a at bits [(a-1)*8 +: 8] |

## Verification
The hardest case to reach is a read frame followed by another read frame. Here the data shifted out belongs to the command before, so each check has to line up the current frame with the command that came ahead of it. The bench sweeps all 128 addresses as one unbroken chain of read frames. It compares each frame's output against the previous address in a model array, and it alternates between raising chip select with the serial clock high and raising it with the clock low. Overlong frames carry a valid-looking write in their discarded leading bits. Bursts of serial clock edges while chip select is high are followed by a frame that proves the shift register was not touched.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;

  // Strobes from the control side, each one system clock wide
  typedef struct packed {
    logic sample;    // capture one data in bit
    logic shiftOut;  // refresh data out from shift register MSB
    logic commit;    // end of frame: decode the command
  } strobes_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= asyncIn;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     sclk,
  input  logic     din,
  output strobes_t strobes,
  output logic     dinSync
);
  logic [2:0] syncBus;
  logic csSync, sclkSync;
  logic csPrev, sclkPrev;
  logic csFall, csRise, sclkRise, sclkFall;

  // All three lines pass through equal depth so their order is kept
  srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({csN, sclk, din}),
    .syncOut(syncBus)
  );

  assign csSync   = syncBus[2];
  assign sclkSync = syncBus[1];
  assign dinSync  = syncBus[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign csFall   = csPrev & ~csSync;
  assign csRise   = ~csPrev & csSync;
  assign sclkRise = ~sclkPrev & sclkSync;
  assign sclkFall = sclkPrev & ~sclkSync;

  always_comb begin
    strobes.sample   = sclkRise & ~csSync;
    strobes.shiftOut = (sclkFall & ~csSync) | csFall;
    strobes.commit   = csRise;
  end
endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int LAST_ADDR = 31
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strobes,
  input  logic                       dinSync,
  output logic                       dout,
  output logic [DATA_W*LAST_ADDR-1:0] regBus
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

  logic [FRAME_W-1:0] shReg;
  logic               doutR;
  logic               cmdRead;
  logic [ADDR_W-1:0]  cmdAddr;
  logic [DATA_W-1:0]  cmdData;
  logic               addrHit;
  logic               doWrite;
  logic [DATA_W-1:0]  rdData;
  logic [DATA_W-1:0]  regFile [1:LAST_ADDR];

  assign cmdRead = shReg[FRAME_W-1];
  assign cmdAddr = shReg[FRAME_W-2 -: ADDR_W];
  assign cmdData = shReg[DATA_W-1:0];
  assign addrHit = (cmdAddr != '0) && (cmdAddr <= LAST);
  assign doWrite = strobes.commit && !cmdRead && addrHit;

  // Register file: one storage byte per implemented address
  for (genvar a = 1; a <= LAST_ADDR; a++) begin : g_reg
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)                                     regFile[a] <= '0;
      else if (doWrite && cmdAddr == ADDR_W'(a))     regFile[a] <= cmdData;
    assign regBus[(a-1)*DATA_W +: DATA_W] = regFile[a];
  end

  always_comb begin
    rdData = '0;
    for (int a = 1; a <= LAST_ADDR; a++)
      if (cmdAddr == ADDR_W'(a)) rdData = regFile[a];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shReg <= '0;
    else if (strobes.sample)
      shReg <= {shReg[FRAME_W-2:0], dinSync};
    else if (strobes.commit && cmdRead)
      shReg[DATA_W-1:0] <= rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 doutR <= 1'b0;
    else if (strobes.shiftOut) doutR <= shReg[FRAME_W-1];
  end

  assign dout = doutR;

  // R9: data out moves only on an output strobe
  p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftOut |=> $stable(doutR));

  // R11: shift register idle without a sample or commit strobe
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.sample || strobes.commit) |=> $stable(shReg));

  // R4: registers change only through a write commit
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit && !cmdRead) |=> $stable(regBus));

  // R5: no-op and out-of-range writes leave the file alone
  p_noop_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !cmdRead && !addrHit) |=> $stable(regBus));

  // R7: unimplemented reads load zero
  p_unimpl_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && cmdRead && !addrHit) |=> (shReg[DATA_W-1:0] == '0));

  // R6: a read keeps the command byte in the upper half
  p_read_keeps_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && cmdRead) |=> (shReg[FRAME_W-1:DATA_W] == $past(shReg[FRAME_W-1:DATA_W])));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int LAST_ADDR   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        csN,
  input  logic                        sclk,
  input  logic                        din,
  output logic                        dout,
  output logic [DATA_W*LAST_ADDR-1:0] regBus
);
  strobes_t strobes;
  logic     dinSync;

  srp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .din    (din),
    .strobes(strobes),
    .dinSync(dinSync)
  );

  srp_datapath #(.LAST_ADDR(LAST_ADDR)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dinSync(dinSync),
    .dout   (dout),
    .regBus (regBus)
  );
endmodule

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int LAST       = 31;

  logic clk = 0, rstN = 0, csN = 1, sclk = 0, din = 0;
  logic dout;
  logic [8*LAST-1:0] regBus;

  int testsRun = 0, testsFailed = 0;
  logic [7:0] model [0:127];
  logic [31:0] got;
  logic [15:0] prevFrame;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_port #(.LAST_ADDR(LAST)) i_serial_reg_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .dout(dout), .regBus(regBus)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send n bits MSB first, collect what dout shows before each rising sclk
  task automatic frame(input logic [31:0] bits, input int n, input bit endHigh, output logic [31:0] rx);
    bit unstable = 0;
    rx = '0;
    csN = 0;
    waitClk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      waitClk(HALF);
      rx[i] = dout;
      sclk = 1;
      waitClk(HALF);
      if (dout !== rx[i]) unstable = 1;
      if (i > 0 || !endHigh) sclk = 0;
    end
    if (endHigh) begin
      csN = 1;
      waitClk(HALF);
      sclk = 0;
    end else begin
      waitClk(HALF);
      csN = 1;
    end
    waitClk(HALF);
    check(!unstable, "R9 dout held through sclk high", {31'b0, unstable}, 32'b0);
  endtask

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 11) ^ (a << 3));
  endfunction

  function automatic logic [8*LAST-1:0] modelBus();
    logic [8*LAST-1:0] b;
    for (int a = 1; a <= LAST; a++) b[(a-1)*8 +: 8] = model[a];
    return b;
  endfunction

  initial begin
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    waitClk(3);
    rstN = 1;
    waitClk(3);

    // R1: reset state
    check(regBus == '0, "R1 registers zero after reset", 32'(regBus[31:0]), 32'h0);
    check(regBus[(4-1)*8] == 1'b0, "R1 run bit clear (shutdown)", 32'(regBus[(4-1)*8]), 32'h0);
    check(dout == 1'b0, "R1 dout low after reset", 32'(dout), 32'h0);

    // R1, R6, R7: chained read sweep of reset contents
    frame(32'h8000, 16, 0, got);
    for (int a = 1; a <= 128; a++) begin
      logic [15:0] cmd;
      cmd = (a < 128) ? {1'b1, 7'(a), 8'h00} : 16'h0000;
      frame(32'(cmd), 16, a[0], got);
      check(got[15:0] == {1'b1, 7'(a-1), 8'h00}, "R6 R1 reset readback", got, {16'h0, 1'b1, 7'(a-1), 8'h00});
    end

    // R4, R10: write every implemented address, chained
    prevFrame = 16'h0000;
    for (int a = 1; a <= LAST; a++) begin
      logic [15:0] cmd;
      cmd = {1'b0, 7'(a), pattern(a)};
      frame(32'(cmd), 16, a[0], got);
      model[a] = pattern(a);
      check(got[15:0] == prevFrame, "R10 previous write frame shifted out", got, 32'(prevFrame));
      check(regBus == modelBus(), "R4 write stores data at address", 32'(regBus[(a-1)*8 +: 8]), 32'(model[a]));
      prevFrame = cmd;
    end

    // R5: writes to address 0 and out of range change nothing
    frame(32'h00FF, 16, 0, got);
    check(regBus == modelBus(), "R5 no-op write ignored", 32'(regBus[7:0]), 32'(model[1]));
    frame(32'h28AA, 16, 1, got);
    check(regBus == modelBus(), "R5 out-of-range write ignored", 32'(regBus[7:0]), 32'(model[1]));
    frame(32'h7FAA, 16, 0, got);
    check(regBus == modelBus(), "R5 top address write ignored", 32'(regBus[7:0]), 32'(model[1]));

    // R6, R7, R8: chained read sweep, chip select raised with sclk high or low
    frame(32'h8000, 16, 1, got);
    for (int a = 1; a <= 128; a++) begin
      logic [15:0] cmd;
      cmd = (a < 128) ? {1'b1, 7'(a), 8'h5A} : 16'h0000;
      frame(32'(cmd), 16, a[0], got);
      check(got[15:0] == {1'b1, 7'(a-1), model[a-1]}, "R6 R7 R8 readback", got,
            {16'h0, 1'b1, 7'(a-1), model[a-1]});
    end

    // R3: overlong frames, only the last 16 bits count
    frame({8'h00, 8'hA5, 16'h0355}, 24, 0, got);
    model[3] = 8'h55;
    check(regBus == modelBus(), "R3 24-bit frame keeps last 16", 32'(regBus[2*8 +: 8]), 32'h55);
    frame({16'h0477, 16'h0366}, 32, 1, got);
    model[3] = 8'h66;
    check(regBus == modelBus(), "R3 32-bit frame ignores leading write", 32'(regBus[3*8 +: 8]), 32'(model[4]));
    frame(32'h8300, 16, 0, got);
    frame(32'h0000, 16, 0, got);
    check(got[15:0] == 16'h8366, "R3 R2 readback after overlong frame", got, 32'h8366);

    // R2: frame bit order, a write frame comes back MSB first
    frame(32'h1E3C, 16, 0, got);
    model[30] = 8'h3C;
    frame(32'h0000, 16, 1, got);
    check(got[15:0] == 16'h1E3C, "R2 MSB-first capture", got, 32'h1E3C);

    // R11: sclk activity with chip select high
    frame(32'h8500, 16, 0, got);
    din = 1;
    for (int k = 0; k < 10; k++) begin
      sclk = 1; waitClk(HALF);
      sclk = 0; waitClk(HALF);
    end
    din = 0;
    check(regBus == modelBus(), "R11 registers untouched with cs high", 32'(regBus[7:0]), 32'(model[1]));
    frame(32'h0000, 16, 0, got);
    check(got[15:0] == {8'h85, model[5]}, "R11 shift register untouched with cs high", got,
          {16'h0, 8'h85, model[5]});

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule